// File: doc/BRIEF.md
# Priority-Table Interrupt Resolver

This block picks, from a programmable priority table, the most urgent fast-class source and the most urgent normal-class source. Each table slot carries an enable flag and a source number. The block sees the sources that are both pending and unmasked, and a routing vector that assigns each source to the fast or the normal class. It reports both winners together in one 32-bit status word, so that software can read a single word and learn both answers.

Slot 0 is the most urgent. The block walks the slots in order, and the first enabled slot whose source is live in a given class wins that class. The two classes are searched independently from the same table. With the default settings the result is combinational, so a status read always reflects the present inputs. A parameter can add one output register stage for timing closure.

Top module: `prio_resolver`

## Requirements
- R1: When a class has no winner, its 16-bit half of `status` reads 0x003F (source field all ones, flag clear). With no winner in either class, `status` is 0x003F003F.
- R2: A slot whose enable flag (`ent_valid`) is 0 never takes part, even when its source is live.
- R3: A slot whose source number is `NUM_SRC` (40) or above never takes part, even when it is enabled. Its number is not folded onto a lower source.
- R4: The fast class: a slot matches when its source is set in `masked_pend` and its `route_fiq` bit is 1. The winner's source number appears in `status[5:0]` and `status[15]` is set.
- R5: The normal class: a slot matches when its source is set in `masked_pend` and its `route_fiq` bit is 0. The winner's source number appears in `status[21:16]` and `status[31]` is set.
- R6: When several slots match in the same class, the slot with the lowest index wins. This holds for every slot up to the last one, index 39.
- R7: In a half that has a winner, every bit other than the source field and the flag is 0. A live source that no enabled slot names never wins.
- R8: Several slots may name the same source. The result is that source, taken from its most urgent slot.
- R9: With `REG_OUT`=0, `status` follows the inputs within the same cycle. With `REG_OUT`=1, `status` shows the result for the inputs present at the previous rising clock edge, and reads 0x003F003F while `rst_n` is low.
- R10: The fast and normal winners are resolved at the same time and independently, and each may come from any slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only when `REG_OUT`=1 |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| masked_pend | input | NUM_SRC | Per-source pending-and-unmasked vector |
| route_fiq | input | NUM_SRC | Per-source class: 1 fast, 0 normal |
| ent_valid | input | NUM_ENT | Per-slot enable flag |
| ent_id | input | NUM_ENT x ID_W | Per-slot source number |
| status | output | 32 | {irq flag, 9'b0, irq id, fiq flag, 9'b0, fiq id} |

## Verification
The bench builds two copies at the default sizes of 40 sources, 40 slots and 6-bit numbers. One copy uses `REG_OUT`=0 and the other `REG_OUT`=1, and both are driven from the same inputs. The default sizes leave 24 source numbers out of range, so the bench can test that such numbers are ignored and are not folded onto lower sources. They also let the bench reach slot 39 and source 39 at the edge of the table. With both copies running, same-cycle following and one-edge lag are both checked against each vector, and reset is checked on the registered copy.

// File: rtl/prio_resolver_pkg.sv
package prio_resolver_pkg;
  localparam int HALF_W   = 16;
  localparam int STATUS_W = 2 * HALF_W;

  // Empty-half pattern: source field all ones, flag clear.
  function automatic logic [HALF_W-1:0] idle_half(input int id_w);
    logic [HALF_W-1:0] h;
    h = '0;
    for (int b = 0; b < id_w; b++) h[b] = 1'b1;
    return h;
  endfunction
endpackage

// File: rtl/prio_slot_match.sv
module prio_slot_match #(
  parameter int NUM_SRC = 40,
  parameter int ID_W    = 6
) (
  input  logic               slot_en,
  input  logic [ID_W-1:0]    slot_src,
  input  logic [NUM_SRC-1:0] live_src,
  input  logic [NUM_SRC-1:0] fast_src,
  output logic               hit_fast,
  output logic               hit_norm
);
  localparam int SPACE = 1 << ID_W;

  logic [SPACE-1:0] live_ext;
  logic [SPACE-1:0] fast_ext;
  logic             in_range;
  logic             src_live;

  // Zero-extend so that out-of-range numbers read as not live.
  assign live_ext = SPACE'(live_src);
  assign fast_ext = SPACE'(fast_src);
  assign in_range = (int'(slot_src) < NUM_SRC);
  assign src_live = slot_en && in_range && live_ext[slot_src];
  assign hit_fast = src_live &&  fast_ext[slot_src];
  assign hit_norm = src_live && !fast_ext[slot_src];
endmodule

// File: rtl/prio_first_pick.sv
module prio_first_pick #(
  parameter int NUM_ENT = 40,
  parameter int ID_W    = 6
) (
  input  logic [NUM_ENT-1:0]           hit,
  input  logic [NUM_ENT-1:0][ID_W-1:0] src,
  output logic                         found,
  output logic [ID_W-1:0]              win_src
);
  // Walk from the least urgent slot down so the lowest index overwrites last.
  always_comb begin
    found   = 1'b0;
    win_src = '0;
    for (int k = NUM_ENT - 1; k >= 0; k--) begin
      if (hit[k]) begin
        found   = 1'b1;
        win_src = src[k];
      end
    end
  end
endmodule

// File: rtl/prio_half_pack.sv
module prio_half_pack
  import prio_resolver_pkg::*;
#(
  parameter int ID_W = 6
) (
  input  logic              found,
  input  logic [ID_W-1:0]   win_src,
  output logic [HALF_W-1:0] half
);
  localparam logic [HALF_W-1:0] IDLE = idle_half(ID_W);

  always_comb begin
    if (found) begin
      half             = '0;
      half[ID_W-1:0]   = win_src;
      half[HALF_W-1]   = 1'b1;
    end else begin
      half = IDLE;
    end
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_resolver_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_ENT = 40,
  parameter int ID_W    = 6,
  parameter bit REG_OUT = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           masked_pend,
  input  logic [NUM_SRC-1:0]           route_fiq,
  input  logic [NUM_ENT-1:0]           ent_valid,
  input  logic [NUM_ENT-1:0][ID_W-1:0] ent_id,
  output logic [STATUS_W-1:0]          status
);
  localparam logic [HALF_W-1:0]   IDLE_H = idle_half(ID_W);
  localparam logic [STATUS_W-1:0] IDLE_W = {IDLE_H, IDLE_H};

  logic [NUM_ENT-1:0]  hit_fast;
  logic [NUM_ENT-1:0]  hit_norm;
  logic                fast_found;
  logic                norm_found;
  logic [ID_W-1:0]     fast_src;
  logic [ID_W-1:0]     norm_src;
  logic [HALF_W-1:0]   fast_half;
  logic [HALF_W-1:0]   norm_half;
  logic [STATUS_W-1:0] status_nxt;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
    prio_slot_match #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_match (
      .slot_en  (ent_valid[g]),
      .slot_src (ent_id[g]),
      .live_src (masked_pend),
      .fast_src (route_fiq),
      .hit_fast (hit_fast[g]),
      .hit_norm (hit_norm[g])
    );
  end

  prio_first_pick #(.NUM_ENT(NUM_ENT), .ID_W(ID_W)) u_pick_fast (
    .hit (hit_fast), .src (ent_id), .found (fast_found), .win_src (fast_src)
  );

  prio_first_pick #(.NUM_ENT(NUM_ENT), .ID_W(ID_W)) u_pick_norm (
    .hit (hit_norm), .src (ent_id), .found (norm_found), .win_src (norm_src)
  );

  prio_half_pack #(.ID_W(ID_W)) u_pack_fast (
    .found (fast_found), .win_src (fast_src), .half (fast_half)
  );

  prio_half_pack #(.ID_W(ID_W)) u_pack_norm (
    .found (norm_found), .win_src (norm_src), .half (norm_half)
  );

  assign status_nxt = {norm_half, fast_half};

  if (REG_OUT) begin : g_reg
    logic [STATUS_W-1:0] status_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= IDLE_W;
      else        status_q <= status_nxt;
    end
    assign status = status_q;
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst_n;
    assign status = status_nxt;
  end
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int NUM_SRC = 40,
  parameter int NUM_ENT = 40,
  parameter int ID_W    = 6,
  parameter bit REG_OUT = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           masked_pend,
  input  logic [NUM_SRC-1:0]           route_fiq,
  input  logic [NUM_ENT-1:0]           ent_valid,
  input  logic [NUM_ENT-1:0][ID_W-1:0] ent_id,
  input  logic [31:0]                  status
);
  localparam int SPACE = 1 << ID_W;

  logic [NUM_SRC-1:0]           ck_pend;
  logic [NUM_SRC-1:0]           ck_route;
  logic [NUM_ENT-1:0]           ck_valid;
  logic [NUM_ENT-1:0][ID_W-1:0] ck_id;

  if (REG_OUT) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ck_pend <= '0; ck_route <= '0; ck_valid <= '0; ck_id <= '0;
      end else begin
        ck_pend <= masked_pend; ck_route <= route_fiq;
        ck_valid <= ent_valid;  ck_id <= ent_id;
      end
    end
  end else begin : g_pass
    assign ck_pend = masked_pend; assign ck_route = route_fiq;
    assign ck_valid = ent_valid;  assign ck_id = ent_id;
  end

  logic [SPACE-1:0] pend_x, route_x;
  logic [ID_W-1:0]  f_id, i_id;
  logic             f_named, i_named, any_fast, any_norm;

  assign pend_x  = SPACE'(ck_pend);
  assign route_x = SPACE'(ck_route);
  assign f_id    = status[ID_W-1:0];
  assign i_id    = status[16+ID_W-1:16];
  assign any_fast = |(ck_pend & ck_route);
  assign any_norm = |(ck_pend & ~ck_route);

  always_comb begin
    f_named = 1'b0;
    i_named = 1'b0;
    for (int k = 0; k < NUM_ENT; k++) begin
      if (ck_valid[k] && ck_id[k] == f_id) f_named = 1'b1;
      if (ck_valid[k] && ck_id[k] == i_id) i_named = 1'b1;
    end
  end

  AST_FAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !status[15] |-> status[14:0] == 15'h003F); // R1
  AST_NORM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !status[31] |-> status[30:16] == 15'h003F); // R1
  AST_FAST_NAMED: assert property (@(posedge clk) disable iff (!rst_n)
    status[15] |-> f_named); // R2
  AST_NORM_NAMED: assert property (@(posedge clk) disable iff (!rst_n)
    status[31] |-> i_named); // R2
  AST_FAST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    status[15] |-> int'(f_id) < NUM_SRC); // R3
  AST_NORM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    status[31] |-> int'(i_id) < NUM_SRC); // R3
  AST_FAST_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    status[15] |-> (pend_x[f_id] && route_x[f_id])); // R4
  AST_NORM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    status[31] |-> (pend_x[i_id] && !route_x[i_id])); // R5
  AST_FAST_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !any_fast |-> !status[15]); // R4
  AST_NORM_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !any_norm |-> !status[31]); // R5
  AST_FAST_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    status[15] |-> status[14:ID_W] == '0); // R7
  AST_NORM_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    status[31] |-> status[30:16+ID_W] == '0); // R7
endmodule

bind prio_resolver prio_resolver_chk #(
  .NUM_SRC(NUM_SRC), .NUM_ENT(NUM_ENT), .ID_W(ID_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .masked_pend(masked_pend), .route_fiq(route_fiq),
  .ent_valid(ent_valid), .ent_id(ent_id), .status(status)
);

// File: tb/prio_resolver_bench.sv
module prio_resolver_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 40;
  localparam int NE = 40;
  localparam int IW = 6;

  typedef struct packed {
    logic       use_e;
    logic [5:0] slot;
    logic       vld;
    logic [5:0] id;
  } ent_t;

  typedef struct packed {
    logic [39:0] pend;
    logic [39:0] route;
    ent_t        e0;
    ent_t        e1;
    ent_t        e2;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam ent_t NO = '{1'b0, 6'd0, 1'b0, 6'd0};

  localparam vec_t VECS [11] = '{
    // R1: nothing live
    '{40'h0, 40'h0, '{1'b1, 6'd0, 1'b1, 6'd5}, NO, NO, 32'h003F003F, 4'd1},
    // R4: one fast winner
    '{40'h20, 40'h20, '{1'b1, 6'd3, 1'b1, 6'd5}, NO, NO, 32'h003F8005, 4'd4},
    // R5: one normal winner
    '{40'h80, 40'h0, '{1'b1, 6'd10, 1'b1, 6'd7}, NO, NO, 32'h8007003F, 4'd5},
    // R2: disabled slot ignored
    '{40'h80, 40'h0, '{1'b1, 6'd10, 1'b0, 6'd7}, NO, NO, 32'h003F003F, 4'd2},
    // R6: lower slot wins
    '{40'h208, 40'h0, '{1'b1, 6'd4, 1'b1, 6'd9}, '{1'b1, 6'd2, 1'b1, 6'd3}, NO,
      32'h8003003F, 4'd6},
    // R10: both classes at once
    '{40'h80_0000_0004, 40'h80_0000_0000, '{1'b1, 6'd0, 1'b1, 6'd39},
      '{1'b1, 6'd1, 1'b1, 6'd2}, NO, 32'h80028027, 4'd10},
    // R3: numbers 45 and 63 ignored, not folded onto 13
    '{40'h2000, 40'h2000, '{1'b1, 6'd0, 1'b1, 6'd45}, '{1'b1, 6'd1, 1'b1, 6'd63},
      '{1'b1, 6'd5, 1'b1, 6'd13}, 32'h003F800D, 4'd3},
    // R8: one source named twice
    '{40'h1001, 40'h1, '{1'b1, 6'd7, 1'b1, 6'd12}, '{1'b1, 6'd30, 1'b1, 6'd12},
      '{1'b1, 6'd39, 1'b1, 6'd0}, 32'h800C8000, 4'd8},
    // R7: live but unnamed source does not win
    '{40'h30_0000, 40'h10_0000, '{1'b1, 6'd0, 1'b1, 6'd20}, NO, NO,
      32'h003F8014, 4'd7},
    // R6: last slot and last source
    '{40'h80_0000_0000, 40'h0, '{1'b1, 6'd39, 1'b1, 6'd39}, NO, NO,
      32'h8027003F, 4'd6},
    // R10: classes pick from different slots
    '{40'h12, 40'h10, '{1'b1, 6'd2, 1'b1, 6'd1}, '{1'b1, 6'd3, 1'b1, 6'd4},
      '{1'b1, 6'd0, 1'b1, 6'd4}, 32'h80018004, 4'd10}
  };

  logic                     clk;
  logic                     rst_n;
  logic [NS-1:0]            masked_pend;
  logic [NS-1:0]            route_fiq;
  logic [NE-1:0]            ent_valid;
  logic [NE-1:0][IW-1:0]    ent_id;
  logic [31:0]              st_comb;
  logic [31:0]              st_reg;
  int n_checks;
  int n_fail;
  bit done;

  prio_resolver #(.NUM_SRC(NS), .NUM_ENT(NE), .ID_W(IW), .REG_OUT(1'b0)) u_prio_resolver (
    .clk(clk), .rst_n(rst_n), .masked_pend(masked_pend), .route_fiq(route_fiq),
    .ent_valid(ent_valid), .ent_id(ent_id), .status(st_comb)
  );

  prio_resolver #(.NUM_SRC(NS), .NUM_ENT(NE), .ID_W(IW), .REG_OUT(1'b1)) u_prio_resolver_reg (
    .clk(clk), .rst_n(rst_n), .masked_pend(masked_pend), .route_fiq(route_fiq),
    .ent_valid(ent_valid), .ent_id(ent_id), .status(st_reg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  task automatic put_ent(input ent_t e);
    if (e.use_e) begin
      ent_valid[e.slot] = e.vld;
      ent_id[e.slot]    = e.id;
    end
  endtask

  task automatic apply(input vec_t v);
    masked_pend = v.pend;
    route_fiq   = v.route;
    ent_valid   = '0;
    ent_id      = '0;
    put_ent(v.e0);
    put_ent(v.e1);
    put_ent(v.e2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    masked_pend = '0;
    route_fiq = '0;
    ent_valid = '0;
    ent_id = '0;
    repeat (3) @(negedge clk);
    check("R1 reset comb idle", st_comb, 32'h003F003F);
    check("R9 reset reg idle", st_reg, 32'h003F003F);
    apply(VECS[1]);
    @(negedge clk);
    check("R9 reg held idle in reset", st_reg, 32'h003F003F);
    rst_n = 1'b1;

    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      #1;
      check($sformatf("R%0d vec %0d comb", VECS[i].req, i), st_comb, VECS[i].expv);
      @(negedge clk);
      check($sformatf("R9 vec %0d reg", i), st_reg, VECS[i].expv);
    end

    // R9: comb follows at once, reg keeps the old value until the edge
    masked_pend = '0;
    #1;
    check("R9 comb same cycle", st_comb, 32'h003F003F);
    check("R9 reg lags one edge", st_reg, 32'h80018004);
    @(negedge clk);
    check("R9 reg after edge", st_reg, 32'h003F003F);

    // R9: asynchronous reset clears the registered copy mid-cycle
    apply(VECS[2]);
    @(negedge clk);
    check("R9 reg loaded", st_reg, 32'h8007003F);
    #1 rst_n = 1'b0;
    #1;
    check("R9 async reset", st_reg, 32'h003F003F);
    check("R5 comb unaffected by reset", st_comb, 32'h8007003F);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule